// File: doc/BRIEF.md
# Shared Counter with Per-Core Compare Timers

This block keeps one free-running counter that all cores share, and gives each core its own compare register, a compare-pending flag, a small local mask and a routing entry. When the shared count reaches a core's compare value, that core's pending flag is set. When the compare source is unmasked and routed, the flag drives one of the core's interrupt pins. Other interrupt sources feed the same pins through an external level input, and those levels are ORed in.

Software reaches the block through a simple word-addressed register port. The port carries the index of the accessing core. Each core has two windows onto the per-core banks. The local window always addresses the core's own bank. The remote window addresses whichever bank that core's indirection register names. The counter can be stopped through the configuration word, and it accepts a new value only while it is stopped. Reads are combinational from the current state and have no side effects.

Top module: `shared_cmp_timer`

## Requirements
- R1: While running, the counter adds 1 on every clock, wrapping from 0xFFFFFFFF to 0. Reading address 0x01 returns the counter.
- R2: Bit 16 of the config word (address 0x00) stops the counter when written 1 and restarts it when written 0. A stopped counter holds its value. A write to address 0x01 loads the counter only while it is stopped; otherwise the write is ignored.
- R3: After reset, every bank reads as follows: mask 0x32, pending 0, compare 0xFFFFFFFF, route map 0x80000000, indirection index 0. The counter reads 0 and is running.
- R4: In a cycle where the counter runs and equals a core's compare value, bit 1 of that core's pending word (bank offset 0) reads 1 from the next cycle on, until that core's compare register is written.
- R5: A write to the compare register (bank offset 7) clears pending bit 1 in the next cycle. The clear wins over a match in the same cycle.
- R6: Pin p of core c is output bit c*NUM_PINS+p. It is registered and goes high one cycle after either of these holds: the matching external level is high, or the core has pending bit 1, mask bit 1 and route flag set, with map pin field p.
- R7: Writing bank offset 2 sets the mask bits given by the data, and writing offset 3 clears them. Only bits [5:0] exist. Offset 1 reads the mask, and bit 1 is the compare-source enable.
- R8: The route map (bank offset 4) holds the route flag in bit 31 and the pin number in bits [2:0]. A write whose pin field is NUM_PINS or more is ignored.
- R9: The indirection index (bank offset 5) selects which bank the remote window (addresses 0x20 to 0x2F) reaches. A write of a value of NUM_CORES or more is ignored. The local window is at addresses 0x10 to 0x1F.
- R10: The identity offset (6) reads the index of the bank being addressed. Addresses 0x02 (counter high) and bank offset 8 (compare high) read 0. Unknown addresses read 0.
- R11: The config word reads NUM_IRQS/8-1 in bits [7:0], NUM_CORES in bits [15:8] and the stop flag in bit 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_valid_i | input | 1 | Register access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_core_i | input | CORE_W | Index of the accessing core |
| bus_addr_i | input | 8 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| ext_irq_i | input | NUM_CORES*NUM_PINS | Levels from other sources sharing the pins |
| irq_pin_o | output | NUM_CORES*NUM_PINS | Registered per-core interrupt pins |

## Verification
The embedded assertions check on every cycle that the counter steps by one while running, holds while stopped, and loads only while stopped. They also check that a match sets the pending flag and a compare write clears it, that the indirection index and pin field stay in range, and that an unfired, unfed pin stays low. Only the bench scenarios can show the rest: the full read map, the wrap through the compare value, remote-window redirection, rejected writes, and mask gating of a pin while its pending flag stays set. The bench compares every pin against its reference model on every clock.

// File: rtl/sct_pkg.sv
package sct_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned MASK_W   = 6;
  localparam int unsigned CMP_BIT  = 1;
  localparam int unsigned STOP_BIT = 16;
  localparam int unsigned ROUTE_BIT = 31;
  localparam logic [MASK_W-1:0] MASK_RST = 6'h32;

  localparam logic [ADDR_W-1:0] A_CFG    = 8'h00;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 8'h01;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 8'h02;
  localparam logic [3:0] WIN_LOCAL = 4'h1;
  localparam logic [3:0] WIN_REMOTE = 4'h2;

  typedef enum logic [3:0] {
    OFF_PEND  = 4'd0,
    OFF_MASK  = 4'd1,
    OFF_MSET  = 4'd2,
    OFF_MCLR  = 4'd3,
    OFF_MAP   = 4'd4,
    OFF_INDIR = 4'd5,
    OFF_IDENT = 4'd6,
    OFF_CMP   = 4'd7,
    OFF_CMPHI = 4'd8
  } bank_off_e;
endpackage

// File: rtl/sct_counter.sv
module sct_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_wr_i,
  input  logic             stop_val_i,
  input  logic             load_wr_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             stop_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             stop_d;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    stop_d = stop_wr_i ? stop_val_i : stop_o;
    cnt_en = !stop_o || load_wr_i;
    cnt_d  = cnt_o;
    if (stop_o && load_wr_i) cnt_d = load_val_i;
    else if (!stop_o)        cnt_d = cnt_o + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_o <= 1'b0;
      cnt_o  <= '0;
    end else begin
      stop_o <= stop_d;
      if (cnt_en) cnt_o <= cnt_d;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_o |=> cnt_o == $past(cnt_o) + CNT_W'(1)); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_o && !load_wr_i) |=> $stable(cnt_o)); // R2
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_o && load_wr_i) |=> cnt_o == $past(load_val_i)); // R2
endmodule

// File: rtl/sct_core_bank.sv
module sct_core_bank
  import sct_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned NUM_PINS  = 6,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned CORE_W    = 2,
  parameter int unsigned PIN_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_off_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              match_i,
  output logic              pend_o,
  output logic [MASK_W-1:0] mask_o,
  output logic              route_o,
  output logic [PIN_W-1:0]  pin_o,
  output logic [CORE_W-1:0] indir_o,
  output logic [CNT_W-1:0]  cmp_o
);
  logic              pend_d, route_d;
  logic [MASK_W-1:0] mask_d;
  logic [PIN_W-1:0]  pin_d;
  logic [CORE_W-1:0] indir_d;
  logic [CNT_W-1:0]  cmp_d;
  logic              cmp_wr, map_ok, indir_ok;

  always_comb begin
    cmp_wr   = wr_en_i && (wr_off_i == OFF_CMP);
    map_ok   = 32'(wr_data_i[PIN_W-1:0]) < 32'(NUM_PINS);
    indir_ok = wr_data_i < 32'(NUM_CORES);
    pend_d   = pend_o;
    mask_d   = mask_o;
    route_d  = route_o;
    pin_d    = pin_o;
    indir_d  = indir_o;
    cmp_d    = cmp_o;
    if (match_i) pend_d = 1'b1;
    if (wr_en_i) begin
      case (wr_off_i)
        OFF_MSET:  mask_d = mask_o | wr_data_i[MASK_W-1:0];
        OFF_MCLR:  mask_d = mask_o & ~wr_data_i[MASK_W-1:0];
        OFF_MAP: if (map_ok) begin
          route_d = wr_data_i[ROUTE_BIT];
          pin_d   = wr_data_i[PIN_W-1:0];
        end
        OFF_INDIR: if (indir_ok) indir_d = wr_data_i[CORE_W-1:0];
        OFF_CMP: begin
          cmp_d  = wr_data_i[CNT_W-1:0];
          pend_d = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o  <= 1'b0;
      mask_o  <= MASK_RST;
      route_o <= 1'b1;
      pin_o   <= '0;
      indir_o <= '0;
      cmp_o   <= '1;
    end else begin
      pend_o <= pend_d;
      if (wr_en_i) begin
        mask_o  <= mask_d;
        route_o <= route_d;
        pin_o   <= pin_d;
        indir_o <= indir_d;
        cmp_o   <= cmp_d;
      end
    end
  end

  AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (match_i && !cmp_wr) |=> pend_o); // R4
  AST_CMP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> !pend_o); // R5
  AST_INDIR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(indir_o) < 32'(NUM_CORES)); // R9
  AST_PIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pin_o) < 32'(NUM_PINS)); // R8
endmodule

// File: rtl/sct_pin_drive.sv
module sct_pin_drive #(
  parameter int unsigned NUM_PINS = 6,
  parameter int unsigned PIN_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire_i,
  input  logic [PIN_W-1:0]    pin_sel_i,
  input  logic [NUM_PINS-1:0] ext_i,
  output logic [NUM_PINS-1:0] pin_q
);
  logic [NUM_PINS-1:0] sel_oh;
  logic [NUM_PINS-1:0] pin_d;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_comb begin
      sel_oh[p] = (pin_sel_i == PIN_W'(p));
      pin_d[p]  = ext_i[p] | (fire_i & sel_oh[p]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin_d;
  end

  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire_i && ext_i == '0) |=> pin_q == '0); // R6
  AST_PIN_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> (pin_q & $past(sel_oh)) != '0); // R6
endmodule

// File: rtl/shared_cmp_timer.sv
module shared_cmp_timer
  import sct_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned NUM_PINS  = 6,
  parameter int unsigned NUM_IRQS  = 256,
  parameter int unsigned CNT_W     = 32,
  localparam int unsigned CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int unsigned PIN_W    = $clog2(NUM_PINS),
  localparam int unsigned NPIN_ALL = NUM_CORES * NUM_PINS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid_i,
  input  logic                bus_write_i,
  input  logic [CORE_W-1:0]   bus_core_i,
  input  logic [7:0]          bus_addr_i,
  input  logic [31:0]         bus_wdata_i,
  output logic [31:0]         bus_rdata_o,
  input  logic [NPIN_ALL-1:0] ext_irq_i,
  output logic [NPIN_ALL-1:0] irq_pin_o
);
  localparam logic [7:0] IRQ_GROUPS = 8'(NUM_IRQS / 8 - 1);

  logic             stop;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       win, off;
  logic             core_ok, in_bank, wr_cfg, wr_cnt;
  logic [CORE_W-1:0] bank_sel;

  logic              pend_a  [NUM_CORES];
  logic [MASK_W-1:0] mask_a  [NUM_CORES];
  logic              route_a [NUM_CORES];
  logic [PIN_W-1:0]  pin_a   [NUM_CORES];
  logic [CORE_W-1:0] indir_a [NUM_CORES];
  logic [CNT_W-1:0]  cmp_a   [NUM_CORES];

  always_comb begin
    win      = bus_addr_i[7:4];
    off      = bus_addr_i[3:0];
    core_ok  = 32'(bus_core_i) < 32'(NUM_CORES);
    in_bank  = core_ok && (win == WIN_LOCAL || win == WIN_REMOTE);
    bank_sel = (win == WIN_REMOTE) ? indir_a[bus_core_i] : bus_core_i;
    wr_cfg   = bus_valid_i && bus_write_i && (bus_addr_i == A_CFG);
    wr_cnt   = bus_valid_i && bus_write_i && (bus_addr_i == A_CNT_LO);
  end

  sct_counter #(.CNT_W(CNT_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_wr_i  (wr_cfg),
    .stop_val_i (bus_wdata_i[STOP_BIT]),
    .load_wr_i  (wr_cnt),
    .load_val_i (bus_wdata_i[CNT_W-1:0]),
    .stop_o     (stop),
    .cnt_o      (cnt)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic bank_wr, match, fire;
    always_comb begin
      bank_wr = bus_valid_i && bus_write_i && in_bank && (bank_sel == CORE_W'(c));
      match   = !stop && (cnt == cmp_a[c]);
      fire    = pend_a[c] && mask_a[c][CMP_BIT] && route_a[c];
    end

    sct_core_bank #(
      .NUM_CORES (NUM_CORES),
      .NUM_PINS  (NUM_PINS),
      .CNT_W     (CNT_W),
      .CORE_W    (CORE_W),
      .PIN_W     (PIN_W)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (bank_wr),
      .wr_off_i  (off),
      .wr_data_i (bus_wdata_i),
      .match_i   (match),
      .pend_o    (pend_a[c]),
      .mask_o    (mask_a[c]),
      .route_o   (route_a[c]),
      .pin_o     (pin_a[c]),
      .indir_o   (indir_a[c]),
      .cmp_o     (cmp_a[c])
    );

    sct_pin_drive #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_pins (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire_i    (fire),
      .pin_sel_i (pin_a[c]),
      .ext_i     (ext_irq_i[c*NUM_PINS +: NUM_PINS]),
      .pin_q     (irq_pin_o[c*NUM_PINS +: NUM_PINS])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_valid_i && !bus_write_i) begin
      if (bus_addr_i == A_CFG) begin
        bus_rdata_o[7:0]      = IRQ_GROUPS;
        bus_rdata_o[15:8]     = 8'(NUM_CORES);
        bus_rdata_o[STOP_BIT] = stop;
      end else if (bus_addr_i == A_CNT_LO) begin
        bus_rdata_o = DATA_W'(cnt);
      end else if (in_bank) begin
        case (off)
          OFF_PEND:  bus_rdata_o[CMP_BIT] = pend_a[bank_sel];
          OFF_MASK:  bus_rdata_o = DATA_W'(mask_a[bank_sel]);
          OFF_MAP: begin
            bus_rdata_o[ROUTE_BIT]   = route_a[bank_sel];
            bus_rdata_o[PIN_W-1:0]   = pin_a[bank_sel];
          end
          OFF_INDIR: bus_rdata_o = DATA_W'(indir_a[bank_sel]);
          OFF_IDENT: bus_rdata_o = DATA_W'(bank_sel);
          OFF_CMP:   bus_rdata_o = DATA_W'(cmp_a[bank_sel]);
          default:   bus_rdata_o = '0;
        endcase
      end
    end
  end

  AST_CNT_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_i && !bus_write_i && bus_addr_i == A_CNT_HI) |-> bus_rdata_o == '0); // R10
endmodule

// File: tb/shared_cmp_timer_tb.sv
module shared_cmp_timer_tb;
  localparam int NC = 4;
  localparam int NP = 6;
  localparam int NI = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        bv = 1'b0, bw = 1'b0;
  logic [1:0]  bc = '0;
  logic [7:0]  ba = '0;
  logic [31:0] bwd = '0;
  wire  [31:0] brd;
  logic [NC*NP-1:0] ext = '0;
  wire  [NC*NP-1:0] pins;

  shared_cmp_timer #(.NUM_CORES(NC), .NUM_PINS(NP), .NUM_IRQS(NI), .CNT_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid_i(bv), .bus_write_i(bw), .bus_core_i(bc),
    .bus_addr_i(ba), .bus_wdata_i(bwd), .bus_rdata_o(brd), .ext_irq_i(ext), .irq_pin_o(pins)
  );

  // reference model state
  bit         m_stop;
  bit [31:0]  m_cnt;
  bit [31:0]  m_cmp [NC];
  bit         m_pend[NC];
  bit [5:0]   m_mask[NC];
  bit         m_route[NC];
  int         m_pin [NC];
  int         m_ind [NC];
  bit [NC*NP-1:0] m_pins;
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic bit [31:0] m_read(int core, bit [7:0] a);
    int b;
    if (a == 8'h00) return {15'b0, m_stop, 8'(NC), 8'(NI/8 - 1)};
    if (a == 8'h01) return m_cnt;
    if (a[7:4] == 4'h1 || a[7:4] == 4'h2) begin
      b = (a[7:4] == 4'h2) ? m_ind[core] : core;
      case (a[3:0])
        4'd0: return {30'b0, m_pend[b], 1'b0};
        4'd1: return {26'b0, m_mask[b]};
        4'd4: return {m_route[b], 28'b0, 3'(m_pin[b])};
        4'd5: return 32'(m_ind[b]);
        4'd6: return 32'(b);
        4'd7: return m_cmp[b];
        default: return 32'h0;
      endcase
    end
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stop = 0; m_cnt = 0; m_pins = '0;
      for (int c = 0; c < NC; c++) begin
        m_cmp[c] = 32'hFFFF_FFFF; m_pend[c] = 0; m_mask[c] = 6'h32;
        m_route[c] = 1; m_pin[c] = 0; m_ind[c] = 0;
      end
    end else begin
      bit [NC*NP-1:0] np;
      bit match[NC];
      bit old_stop;
      int b;
      for (int c = 0; c < NC; c++) begin
        for (int p = 0; p < NP; p++)
          np[c*NP+p] = ext[c*NP+p] | (m_pend[c] && m_mask[c][1] && m_route[c] && m_pin[c] == p);
        match[c] = !m_stop && (m_cnt == m_cmp[c]);
      end
      for (int c = 0; c < NC; c++) if (match[c]) m_pend[c] = 1;
      old_stop = m_stop;
      if (bv && bw) begin
        if (ba == 8'h00) m_stop = bwd[16];
        if (ba[7:4] == 4'h1 || ba[7:4] == 4'h2) begin
          b = (ba[7:4] == 4'h2) ? m_ind[bc] : int'(bc);
          case (ba[3:0])
            4'd2: m_mask[b] = m_mask[b] | bwd[5:0];
            4'd3: m_mask[b] = m_mask[b] & ~bwd[5:0];
            4'd4: if (bwd[2:0] < NP) begin m_route[b] = bwd[31]; m_pin[b] = bwd[2:0]; end
            4'd5: if (bwd < NC) m_ind[b] = bwd;
            4'd7: begin m_cmp[b] = bwd; m_pend[b] = 0; end
            default: ;
          endcase
        end
      end
      if (bv && bw && ba == 8'h01 && old_stop) m_cnt = bwd;
      else if (!old_stop) m_cnt = m_cnt + 1;
      m_pins = np;
    end
  end

  // R6: pins compared against the model every clock
  always @(negedge clk) if (rst_n && !done) chk("R6 pins", 32'(pins), 32'(m_pins));

  task automatic wr(int core, bit [7:0] a, bit [31:0] d);
    @(negedge clk);
    bv = 1; bw = 1; bc = 2'(core); ba = a; bwd = d;
    @(negedge clk);
    bv = 0; bw = 0;
  endtask

  task automatic rd(int core, bit [7:0] a, string tag);
    @(negedge clk);
    bv = 1; bw = 0; bc = 2'(core); ba = a;
    #1;
    chk(tag, brd, m_read(core, a));
    bv = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(4);
    rst_n = 1;
    // R3 reset values and R11 config
    @(negedge clk); bv = 1; bw = 0; ba = 8'h00; #1;
    chk("R11 config literal", brd, 32'h0000_041F); bv = 0;
    for (int c = 0; c < NC; c++) begin
      rd(c, 8'h10, "R3 pend");
      rd(c, 8'h11, "R3 mask");
      rd(c, 8'h14, "R3 map");
      rd(c, 8'h15, "R3 indir");
      rd(c, 8'h17, "R3 compare");
    end
    rd(0, 8'h01, "R1 count");
    idle(7);
    rd(0, 8'h01, "R1 count later");
    // R2 running counter write ignored
    wr(0, 8'h01, 32'h0000_0055);
    rd(0, 8'h01, "R2 write while running");
    // R2 stop and load
    wr(0, 8'h00, 32'h0001_0000);
    rd(0, 8'h00, "R11 stop flag");
    wr(0, 8'h01, 32'hFFFF_FFF0);
    idle(3);
    rd(0, 8'h01, "R2 loaded and held");
    // R4 match through wrap, R8 map
    wr(0, 8'h17, 32'hFFFF_FFF8);
    wr(0, 8'h14, 32'h8000_0002);
    rd(0, 8'h14, "R8 map write");
    wr(0, 8'h00, 32'h0);
    idle(20);
    rd(0, 8'h10, "R4 pending after match");
    chk("R6 core0 pin2", 32'(pins[2]), 32'h1);
    rd(0, 8'h01, "R1 wrapped count");
    // R5 compare write clears; external level holds pin
    ext[2] = 1;
    wr(0, 8'h17, 32'h8000_0000);
    rd(0, 8'h10, "R5 pending cleared");
    idle(2);
    chk("R6 ext holds pin", 32'(pins[2]), 32'h1);
    ext[2] = 0;
    idle(2);
    chk("R5 pin released", 32'(pins[2]), 32'h0);
    // R7 mask set/clear
    wr(0, 8'h13, 32'h0000_0002);
    rd(0, 8'h11, "R7 mask clear");
    wr(0, 8'h12, 32'hFFFF_FFFF);
    rd(0, 8'h11, "R7 mask set limited");
    // R8 out-of-range pin ignored, route off
    wr(0, 8'h14, 32'h8000_0007);
    rd(0, 8'h14, "R8 bad pin ignored");
    wr(0, 8'h14, 32'h0000_0005);
    rd(0, 8'h14, "R8 route off");
    // R6/R7 mask gating on core 1
    wr(1, 8'h00, 32'h0001_0000);
    wr(1, 8'h01, 32'd100);
    wr(1, 8'h17, 32'd105);
    wr(1, 8'h14, 32'h8000_0004);
    wr(1, 8'h13, 32'h0000_0002);
    wr(1, 8'h00, 32'h0);
    idle(15);
    rd(1, 8'h10, "R4 pending while masked");
    chk("R7 masked pin low", 32'(pins[NP+4]), 32'h0);
    wr(1, 8'h12, 32'h0000_0002);
    idle(1);
    chk("R6 unmasked pin high", 32'(pins[NP+4]), 32'h1);
    // R9 remote window and R10 identity
    wr(1, 8'h15, 32'd3);
    wr(1, 8'h27, 32'h0000_1234);
    rd(3, 8'h17, "R9 remote compare write");
    rd(1, 8'h26, "R10 identity remote");
    rd(2, 8'h16, "R10 identity local");
    wr(1, 8'h15, 32'd4);
    rd(1, 8'h15, "R9 bad index ignored");
    rd(1, 8'h25, "R9 remote indir read");
    rd(0, 8'h02, "R10 counter high");
    rd(0, 8'h18, "R10 compare high");
    rd(0, 8'h3C, "R10 unknown address");
    idle(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule